// File: doc/BRIEF.md
# In-band management command executor with utility bus master

This block carries out management commands that have already been pulled out of in-band control cells. Each command arrives as a code byte and two parameter bytes, A and B. The block acts on the command in one of several ways:

- It runs a write or read cycle on an 8-bit multiplexed address/data utility bus, driving chip select, address latch enable and separate read and write strobes.
- It holds the PHY reset line low for a fixed number of cycles.
- It drives two general-purpose output pins.
- It reports status.
- It reloads the identifier that the upstream cell filter compares against.

Some commands need an answer. For those, and on every new rising edge of the PHY interrupt input, the block posts a reply request. The request carries a command byte and two data bytes, and a reply-cell generator downstream turns them into a full cell.

A command that arrives while a bus cycle or the PHY reset pulse is still running is dropped. Unknown command codes are dropped as well. Only one reply request can be posted per cycle. When a command reply and an interrupt notification fall due in the same cycle, the command reply goes first and the notification is posted in the cycle after it.

Top module: `mce_top`

## Requirements
- R1: After reset: bus_cs_n=1, bus_ale=0, bus_rd_n=1, bus_wr_n=1, bus_oe=0, phy_rst_n=1, pin_a=pin_b=0, ctl_id=DEFAULT_ID (0x1F), rep_valid=0, cmd_busy=0.
- R2: Code 0x01 drives phy_rst_n low for exactly RST_CYCLES (16) cycles, starting the cycle after acceptance, and posts no reply.
- R3: Code 0x02 first runs an address phase of ALE_CYCLES (2) cycles: bus_cs_n=0, bus_ale=1, bus_oe=1, bus_dout=A. A data phase of WR_CYCLES (2) cycles follows: bus_ale=0, bus_wr_n=0, bus_dout=B. The bus is then idle, with cmd_busy low 1+ALE_CYCLES+WR_CYCLES cycles after acceptance. No reply is posted.
- R4: Code 0x03 runs the same address phase. It then releases the bus (bus_oe=0) and holds bus_rd_n low for RD_CYCLES (4) cycles, capturing bus_din at the edge that ends the strobe. The reply comes 1+ALE_CYCLES+RD_CYCLES cycles after acceptance and carries rep_cmd=0x03, rep_d1=A and rep_d2=the captured byte.
- R5: Code 0x04 sets pin_a=B[1] and pin_b=B[0] on the cycle after acceptance, so B values 0,1,2,3 give low/low, low/high, high/low and high/high. In that same cycle it posts a reply with rep_cmd=0x04, rep_d1={irq,7'b0} and rep_d2=REVISION.
- R6: Code 0x05 posts a reply the cycle after acceptance with rep_cmd=0x05, rep_d1 bit 7 equal to the synchronised interrupt level, rep_d1[6:0]=0 and rep_d2=REVISION.
- R7: Code 0x06 loads A into ctl_id on the cycle after acceptance and posts no reply.
- R8: The phy_irq input passes through a 2-flop synchroniser. Each rising edge of the synchronised level posts a reply with rep_cmd=0x00, rep_d1=0x80 and rep_d2=REVISION, visible 3 cycles after phy_irq rises. A held high level or a falling edge posts nothing.
- R9: If a command reply and an interrupt notification fall due at the same edge, the command reply is posted first and the notification follows in the next cycle.
- R10: A command presented while cmd_busy is high, during a bus cycle or a reset pulse, has no effect on the bus, pins, ctl_id or replies.
- R11: The codes 0x00 and 0x07 to 0xFF are ignored: no bus cycle, no reply, no change to pins or ctl_id.
- R12: bus_rd_n and bus_wr_n are never low together, and bus_cs_n is low whenever bus_ale, bus_rd_n or bus_wr_n is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_code | input | 8 | Command code byte |
| cmd_a | input | 8 | Parameter byte A |
| cmd_b | input | 8 | Parameter byte B |
| cmd_busy | output | 1 | High while a bus cycle or reset pulse runs |
| bus_cs_n | output | 1 | Utility bus chip select, active low |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Output enable for the address/data pads |
| bus_dout | output | 8 | Address or write data driven to the pads |
| bus_din | input | 8 | Data read back from the pads |
| phy_irq | input | 1 | Asynchronous PHY interrupt level |
| phy_rst_n | output | 1 | PHY reset, active low |
| pin_a | output | 1 | General-purpose output A |
| pin_b | output | 1 | General-purpose output B |
| ctl_id | output | 8 | Control-cell identifier used by the filter |
| rep_valid | output | 1 | One-cycle reply request |
| rep_cmd | output | 8 | Reply command byte |
| rep_d1 | output | 8 | Reply data byte 1 |
| rep_d2 | output | 8 | Reply data byte 2 |

## Verification
Every result has a fixed latency, counted in clock edges from the edge that accepts the stimulus:

| Result | Due |
|---|---|
| Pin, identifier and status results | next cycle |
| Read reply | 1+ALE_CYCLES+RD_CYCLES = 7 |
| End of a write | 1+ALE_CYCLES+WR_CYCLES = 5 |
| Release of the PHY reset | 17 |
| Interrupt notification (two synchroniser flops plus the reply register) | 3 |

The bench counts edges explicitly, samples on the falling edge after the edge it counted, and checks both the due cycle and the cycles on either side of it. That way an early or late output is reported, not just a wrong value.

// File: rtl/mce_pkg.sv
package mce_pkg;

  typedef enum logic [1:0] {BUS_IDLE, BUS_ADDR, BUS_DATA} bus_state_e;

  localparam logic [7:0] CODE_IRQ    = 8'h00;
  localparam logic [7:0] CODE_PHYRST = 8'h01;
  localparam logic [7:0] CODE_WRITE  = 8'h02;
  localparam logic [7:0] CODE_READ   = 8'h03;
  localparam logic [7:0] CODE_PINS   = 8'h04;
  localparam logic [7:0] CODE_STATUS = 8'h05;
  localparam logic [7:0] CODE_SETID  = 8'h06;

  // Reply data byte that reports the interrupt level in its top bit.
  function automatic logic [7:0] irq_byte(input logic lvl);
    return {lvl, 7'b0};
  endfunction

  // Output pin pair {a,b} from the low two bits of parameter B.
  function automatic logic [1:0] pin_decode(input logic [1:0] sel);
    return {sel[1], sel[0]};
  endfunction

  function automatic logic code_known(input logic [7:0] code);
    return (code >= CODE_PHYRST) && (code <= CODE_SETID);
  endfunction

  function automatic logic code_replies(input logic [7:0] code);
    return (code == CODE_PINS) || (code == CODE_STATUS);
  endfunction

endpackage

// File: rtl/mce_irq_sync.sv
module mce_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  output logic irq_lvl,
  output logic irq_rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], irq_in};
  end

  assign irq_lvl  = sh[STAGES-1];
  assign irq_rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/mce_rst_pulse.sv
module mce_rst_pulse #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic pulse_n
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CW'(CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign active  = (cnt != '0);
  assign pulse_n = ~active;
endmodule

// File: rtl/mce_bus_seq.sv
module mce_bus_seq
  import mce_pkg::*;
#(
  parameter int ALE_CYC = 2,
  parameter int RD_CYC  = 4,
  parameter int WR_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_read,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic       busy,
  output logic       rd_done,
  output logic [7:0] cur_addr,
  output logic       cs_n,
  output logic       ale,
  output logic       rd_n,
  output logic       wr_n,
  output logic       oe,
  output logic [7:0] dout
);
  localparam int MAXC = (ALE_CYC > RD_CYC) ? ((ALE_CYC > WR_CYC) ? ALE_CYC : WR_CYC)
                                           : ((RD_CYC > WR_CYC) ? RD_CYC : WR_CYC);
  localparam int CW = $clog2(MAXC) + 1;

  bus_state_e    st;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic [7:0]    a_q;
  logic [7:0]    d_q;
  logic          addr_last;
  logic          data_last;

  assign addr_last = (st == BUS_ADDR) && (cnt == CW'(ALE_CYC - 1));
  assign data_last = (st == BUS_DATA) &&
                     (cnt == (rd_q ? CW'(RD_CYC - 1) : CW'(WR_CYC - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= BUS_IDLE;
      cnt  <= '0;
      rd_q <= 1'b0;
      a_q  <= '0;
      d_q  <= '0;
    end else begin
      case (st)
        BUS_IDLE: if (start) begin
          st   <= BUS_ADDR;
          cnt  <= '0;
          rd_q <= is_read;
          a_q  <= addr;
          d_q  <= wdata;
        end
        BUS_ADDR: begin
          if (addr_last) begin
            st  <= BUS_DATA;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        BUS_DATA: begin
          if (data_last) st <= BUS_IDLE;
          else           cnt <= cnt + 1'b1;
        end
        default: st <= BUS_IDLE;
      endcase
    end
  end

  assign busy     = (st != BUS_IDLE);
  assign rd_done  = data_last && rd_q;
  assign cur_addr = a_q;
  assign cs_n     = (st == BUS_IDLE);
  assign ale      = (st == BUS_ADDR);
  assign rd_n     = ~((st == BUS_DATA) && rd_q);
  assign wr_n     = ~((st == BUS_DATA) && !rd_q);
  assign oe       = (st == BUS_ADDR) || ((st == BUS_DATA) && !rd_q);
  assign dout     = (st == BUS_ADDR) ? a_q :
                    ((st == BUS_DATA) && !rd_q) ? d_q : 8'h00;
endmodule

// File: rtl/mce_top.sv
module mce_top
  import mce_pkg::*;
#(
  parameter logic [7:0] REVISION    = 8'h21,
  parameter logic [7:0] DEFAULT_ID  = 8'h1F,
  parameter int         RST_CYCLES  = 16,
  parameter int         ALE_CYCLES  = 2,
  parameter int         RD_CYCLES   = 4,
  parameter int         WR_CYCLES   = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic [7:0] cmd_a,
  input  logic [7:0] cmd_b,
  output logic       cmd_busy,
  output logic       bus_cs_n,
  output logic       bus_ale,
  output logic       bus_rd_n,
  output logic       bus_wr_n,
  output logic       bus_oe,
  output logic [7:0] bus_dout,
  input  logic [7:0] bus_din,
  input  logic       phy_irq,
  output logic       phy_rst_n,
  output logic       pin_a,
  output logic       pin_b,
  output logic [7:0] ctl_id,
  output logic       rep_valid,
  output logic [7:0] rep_cmd,
  output logic [7:0] rep_d1,
  output logic [7:0] rep_d2
);
  // Named internal events, also observed by the bound checker.
  logic       cmd_accept;
  logic       bus_busy;
  logic       rst_active;
  logic       rd_done;
  logic [7:0] cur_addr;
  logic       irq_lvl;
  logic       irq_rise;
  logic       irq_pend;
  logic       irq_req;
  logic       cmd_rep;
  logic       bus_start;

  assign cmd_busy   = bus_busy | rst_active;
  assign cmd_accept = cmd_valid && !cmd_busy && code_known(cmd_code);
  assign bus_start  = cmd_accept &&
                      ((cmd_code == CODE_WRITE) || (cmd_code == CODE_READ));
  assign cmd_rep    = rd_done || (cmd_accept && code_replies(cmd_code));
  assign irq_req    = irq_pend | irq_rise;

  mce_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .irq_in(phy_irq),
    .irq_lvl(irq_lvl), .irq_rise(irq_rise)
  );

  mce_rst_pulse #(.CYCLES(RST_CYCLES)) u_rstp (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_accept && (cmd_code == CODE_PHYRST)),
    .active(rst_active), .pulse_n(phy_rst_n)
  );

  mce_bus_seq #(.ALE_CYC(ALE_CYCLES), .RD_CYC(RD_CYCLES), .WR_CYC(WR_CYCLES)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start),
    .is_read(cmd_code == CODE_READ), .addr(cmd_a), .wdata(cmd_b),
    .busy(bus_busy), .rd_done(rd_done), .cur_addr(cur_addr),
    .cs_n(bus_cs_n), .ale(bus_ale), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
    .oe(bus_oe), .dout(bus_dout)
  );

  // Pins and filter identifier.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_a  <= 1'b0;
      pin_b  <= 1'b0;
      ctl_id <= DEFAULT_ID;
    end else if (cmd_accept) begin
      if (cmd_code == CODE_PINS)  {pin_a, pin_b} <= pin_decode(cmd_b[1:0]);
      if (cmd_code == CODE_SETID) ctl_id <= cmd_a;
    end
  end

  // Reply posting: command replies win, interrupt notices wait one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_valid <= 1'b0;
      rep_cmd   <= '0;
      rep_d1    <= '0;
      rep_d2    <= '0;
      irq_pend  <= 1'b0;
    end else begin
      rep_valid <= cmd_rep | irq_req;
      irq_pend  <= cmd_rep & irq_req;
      if (rd_done) begin
        rep_cmd <= CODE_READ;
        rep_d1  <= cur_addr;
        rep_d2  <= bus_din;
      end else if (cmd_rep) begin
        rep_cmd <= cmd_code;
        rep_d1  <= irq_byte(irq_lvl);
        rep_d2  <= REVISION;
      end else if (irq_req) begin
        rep_cmd <= CODE_IRQ;
        rep_d1  <= irq_byte(irq_lvl);
        rep_d2  <= REVISION;
      end
    end
  end
endmodule

// File: rtl/mce_checker.sv
module mce_checker #(
  parameter logic [7:0] REVISION = 8'h21
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_busy,
  input logic       cmd_accept,
  input logic [7:0] cmd_code,
  input logic [7:0] cmd_b,
  input logic       bus_cs_n,
  input logic       bus_ale,
  input logic       bus_rd_n,
  input logic       bus_wr_n,
  input logic       bus_oe,
  input logic       pin_a,
  input logic       pin_b,
  input logic [7:0] ctl_id,
  input logic       rep_valid,
  input logic [7:0] rep_cmd,
  input logic [7:0] rep_d1,
  input logic [7:0] rep_d2
);
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  p_cs_cover_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ale || !bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

  p_rd_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_oe);

  p_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && cmd_code == 8'h04) |=> ({pin_a, pin_b} == $past(cmd_b[1:0])));

  p_stat_fmt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && rep_cmd == 8'h05) |-> (rep_d1[6:0] == 7'd0 && rep_d2 == REVISION));

  p_irq_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && rep_cmd == 8'h00) |-> (rep_d1 == 8'h80 && rep_d2 == REVISION));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_busy) |=> ($stable(ctl_id) && $stable({pin_a, pin_b})));

  p_unknown_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_busy && (cmd_code == 8'h00 || cmd_code > 8'h06))
      |=> (bus_cs_n && $stable(ctl_id) && $stable({pin_a, pin_b})));
endmodule

bind mce_top mce_checker #(.REVISION(REVISION)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_busy(cmd_busy),
  .cmd_accept(cmd_accept), .cmd_code(cmd_code), .cmd_b(cmd_b),
  .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n), .bus_oe(bus_oe), .pin_a(pin_a), .pin_b(pin_b),
  .ctl_id(ctl_id), .rep_valid(rep_valid), .rep_cmd(rep_cmd),
  .rep_d1(rep_d1), .rep_d2(rep_d2)
);

// File: tb/mce_top_bench.sv
module mce_top_bench;
  localparam logic [7:0] REV = 8'h21;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0, cmd_a = '0, cmd_b = '0;
  logic       phy_irq = 1'b0;
  logic       cmd_busy, bus_cs_n, bus_ale, bus_rd_n, bus_wr_n, bus_oe;
  logic [7:0] bus_dout, bus_din, ctl_id, rep_cmd, rep_d1, rep_d2;
  logic       phy_rst_n, pin_a, pin_b, rep_valid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mce_top #(.REVISION(REV)) u_mce_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_busy(cmd_busy), .bus_cs_n(bus_cs_n),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din),
    .phy_irq(phy_irq), .phy_rst_n(phy_rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .ctl_id(ctl_id), .rep_valid(rep_valid), .rep_cmd(rep_cmd),
    .rep_d1(rep_d1), .rep_d2(rep_d2)
  );

  // Simple register-file model of the device on the utility bus.
  logic [7:0] mem [256];
  logic [7:0] phy_addr = '0;
  assign bus_din = mem[phy_addr];
  always @(negedge clk) begin
    if (bus_ale && !bus_cs_n) phy_addr <= bus_dout;
    if (!bus_wr_n && !bus_cs_n) mem[phy_addr] <= bus_dout;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Drive a command for one edge; returns at the sample point one cycle later.
  task automatic issue(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
    cmd_valid = 1'b1; cmd_code = c; cmd_a = a; cmd_b = b;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(bus_cs_n && !bus_ale && bus_rd_n && bus_wr_n && !bus_oe, "R1 bus idle",
        {bus_cs_n, bus_ale, bus_rd_n, bus_wr_n, bus_oe}, 5'b10110);
    chk(phy_rst_n && !pin_a && !pin_b, "R1 pins", {phy_rst_n, pin_a, pin_b}, 3'b100);
    chk(ctl_id == 8'h1F, "R1 ctl_id", ctl_id, 8'h1F);
    chk(!rep_valid && !cmd_busy, "R1 rep/busy", {rep_valid, cmd_busy}, 0);
  endtask

  task automatic t_write();
    issue(8'h02, 8'h3C, 8'h5A);
    for (int n = 1; n <= 5; n++) begin
      if (n <= 2) begin
        chk(!bus_cs_n && bus_ale && bus_oe && bus_wr_n && bus_dout == 8'h3C,
            "R3 addr phase", bus_dout, 8'h3C);
      end else if (n <= 4) begin
        chk(!bus_cs_n && !bus_ale && !bus_wr_n && bus_rd_n && bus_dout == 8'h5A,
            "R3/R12 write phase", {bus_wr_n, bus_dout}, 8'h5A);
      end else begin
        chk(bus_cs_n && bus_wr_n && !cmd_busy, "R3 end", {bus_cs_n, cmd_busy}, 2'b10);
      end
      chk(!rep_valid, "R3 no reply", rep_valid, 0);
      if (n < 5) tick();
    end
    tick();
    chk(mem[8'h3C] == 8'h5A, "R3 data stored", mem[8'h3C], 8'h5A);
  endtask

  task automatic t_read();
    mem[8'h77] = 8'hC3;
    issue(8'h03, 8'h77, 8'hEE);
    for (int n = 1; n <= 8; n++) begin
      if (n >= 3 && n <= 6)
        chk(!bus_rd_n && !bus_oe && bus_wr_n && !bus_cs_n, "R4/R12 read strobe",
            {bus_rd_n, bus_oe}, 0);
      if (n == 7)
        chk(rep_valid && rep_cmd == 8'h03 && rep_d1 == 8'h77 && rep_d2 == 8'hC3,
            "R4 reply", {rep_valid, rep_cmd, rep_d1, rep_d2}, {1'b1, 24'h0377C3});
      else
        chk(!rep_valid, "R4 reply timing", rep_valid, 0);
      tick();
    end
  endtask

  task automatic t_phyrst();
    issue(8'h01, 8'h00, 8'h00);
    for (int n = 1; n <= 17; n++) begin
      if (n <= 16) chk(!phy_rst_n && !rep_valid, "R2 pulse low", {phy_rst_n, rep_valid}, 0);
      else         chk(phy_rst_n, "R2 pulse end", phy_rst_n, 1);
      if (n < 17) tick();
    end
  endtask

  task automatic t_pins();
    for (int b = 0; b < 4; b++) begin
      issue(8'h04, 8'h99, 8'(b));
      chk(pin_a == b[1] && pin_b == b[0], "R5 pins", {pin_a, pin_b}, b);
      chk(rep_valid && rep_cmd == 8'h04 && rep_d2 == REV, "R5 reply",
          {rep_valid, rep_cmd}, {1'b1, 8'h04});
    end
  endtask

  task automatic t_status(input logic lvl);
    issue(8'h05, 8'h00, 8'h00);
    chk(rep_valid && rep_cmd == 8'h05 && rep_d1 == {lvl, 7'b0} && rep_d2 == REV,
        "R6 status reply", {rep_cmd, rep_d1, rep_d2}, {8'h05, lvl, 7'b0, REV});
  endtask

  task automatic t_setid();
    issue(8'h06, 8'h42, 8'h11);
    chk(ctl_id == 8'h42 && !rep_valid, "R7 id load", ctl_id, 8'h42);
    tick();
    chk(!rep_valid, "R7 no reply", rep_valid, 0);
  endtask

  task automatic t_irq();
    phy_irq = 1'b1;
    for (int n = 1; n <= 4; n++) begin
      tick();
      if (n == 3)
        chk(rep_valid && rep_cmd == 8'h00 && rep_d1 == 8'h80 && rep_d2 == REV,
            "R8 notify", {rep_cmd, rep_d1, rep_d2}, {8'h00, 8'h80, REV});
      else
        chk(!rep_valid, "R8 notify timing", rep_valid, 0);
    end
    for (int n = 0; n < 8; n++) begin
      tick();
      chk(!rep_valid, "R8 level held", rep_valid, 0);
    end
    t_status(1'b1);
    phy_irq = 1'b0;
    for (int n = 0; n < 6; n++) begin
      tick();
      chk(!rep_valid, "R8 falling edge", rep_valid, 0);
    end
  endtask

  task automatic t_collide();
    phy_irq = 1'b1;
    tick();
    tick();
    issue(8'h05, 8'h00, 8'h00);
    chk(rep_valid && rep_cmd == 8'h05 && rep_d1 == 8'h80, "R9 command first",
        {rep_cmd, rep_d1}, {8'h05, 8'h80});
    tick();
    chk(rep_valid && rep_cmd == 8'h00 && rep_d1 == 8'h80, "R9 notify next",
        {rep_cmd, rep_d1}, {8'h00, 8'h80});
    tick();
    chk(!rep_valid, "R9 single notify", rep_valid, 0);
    phy_irq = 1'b0;
    repeat (4) tick();
  endtask

  task automatic t_busy();
    logic [7:0] id_before;
    issue(8'h02, 8'h10, 8'h11);
    cmd_valid = 1'b1; cmd_code = 8'h02; cmd_a = 8'h20; cmd_b = 8'h22;
    tick();
    chk(bus_dout == 8'h10, "R10 addr kept", bus_dout, 8'h10);
    tick();
    cmd_valid = 1'b0;
    tick();
    tick();
    chk(!cmd_busy && bus_cs_n, "R10 single cycle", cmd_busy, 0);
    repeat (4) tick();
    chk(mem[8'h20] == (8'h20 ^ 8'hA5), "R10 ignored write", mem[8'h20], 8'h20 ^ 8'hA5);
    chk(mem[8'h10] == 8'h11, "R10 first write", mem[8'h10], 8'h11);
    id_before = ctl_id;
    issue(8'h01, 8'h00, 8'h00);
    issue(8'h06, 8'h99, 8'h00);
    chk(ctl_id == id_before, "R10 id during reset pulse", ctl_id, id_before);
    repeat (20) tick();
  endtask

  task automatic t_unknown();
    logic [7:0] codes [3];
    logic [7:0] id_before;
    codes[0] = 8'h00; codes[1] = 8'h07; codes[2] = 8'hFF;
    id_before = ctl_id;
    for (int i = 0; i < 3; i++) begin
      issue(codes[i], 8'h55, 8'h00);
      chk(!rep_valid && bus_cs_n && !cmd_busy && phy_rst_n, "R11 no action",
          {rep_valid, bus_cs_n, cmd_busy}, 3'b010);
      chk(ctl_id == id_before && pin_a && pin_b, "R11 state kept",
          {ctl_id, pin_a, pin_b}, {id_before, 2'b11});
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_write();
    t_read();
    t_phyrst();
    t_pins();
    t_status(1'b0);
    t_setid();
    t_irq();
    t_collide();
    t_busy();
    t_unknown();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule